// File: doc/BRIEF.md
# Split-Execute Hazard and Bypass Controller

This block is the dependency checker for a short in-order pipeline whose arithmetic stage is cut into two halves, EX-A and EX-B, with a register between them. It compares the two source register numbers of the instruction sitting in decode against the destination tags of the instructions now in EX-A, EX-B and writeback. From that comparison it chooses a bypass source for each operand and decides whether decode must wait.

Because the arithmetic result becomes final only as it leaves EX-B, the half-finished value held after EX-A is never offered as a bypass source. A consumer that directly follows its producer therefore waits one cycle, which the unsplit pipeline did not need. While it waits, fetch and decode hold and an empty slot enters EX-A. The block keeps its own copy of the destination tags for the three downstream stages. These tags advance in step with the pipeline it controls. The datapath, the register file and the operand muxes live outside the block.

Top module: `hz_split_alu_ctrl`

## Requirements
- R1: While reset is held, and after it, until the first instruction is issued, `stall_o` and `exa_bubble_o` are 0 and both selects read 2'b00. All tracked stages start empty.
- R2: `stall_o` and `exa_bubble_o` are 1 in the same cycle if and only if decode holds a valid instruction and the instruction in EX-A writes a register that either source operand names.
- R3: A consumer issued directly after its producer is held for exactly one cycle. In the cycle it issues, its select for that operand is 2'b01.
- R4: An operand whose register is written by the instruction in EX-B gets select 2'b01 (EX-B output), with no stall.
- R5: An operand whose register is written by the instruction in writeback, and not by the one in EX-B, gets select 2'b10.
- R6: An operand matched by no instruction in EX-B or writeback gets select 2'b00 (register file). This includes a producer four or more positions ahead.
- R7: When both EX-B and writeback write the needed register, EX-B wins (2'b01).
- R8: An instruction with its write enable clear, or with destination register 0, never causes a stall or a bypass. Source register 0 always selects 2'b00.
- R9: Each operand's select is decided on its own. A hazard on either operand alone is enough to stall.
- R10: During a stall the held instruction does not enter EX-A. An empty slot that writes nothing enters instead, and the producer moves on to EX-B. The held instruction then enters EX-A exactly once, in the next cycle in which it does not stall.
- R11: A decode slot marked not valid never stalls, whatever its source fields hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. Assertion is asynchronous; release is synchronised inside the block |
| id_valid_i | input | 1 | Decode slot holds a real instruction |
| id_we_i | input | 1 | Decode instruction writes a register |
| id_rd_i | input | ADDR_W | Destination register of the decode instruction |
| id_rs1_i | input | ADDR_W | First source register of the decode instruction |
| id_rs2_i | input | ADDR_W | Second source register of the decode instruction |
| stall_o | output | 1 | Hold the PC and the decode register this cycle |
| exa_bubble_o | output | 1 | Load an empty slot into EX-A this cycle |
| fwd_rs1_o | output | 2 | First operand source: 00 register file, 01 EX-B output, 10 writeback |
| fwd_rs2_o | output | 2 | Second operand source, same encoding |

## Verification
A stale or shifted destination tag inside the block shows up as a wrong select or a wrong stall in the cycle the next dependent instruction reaches decode. That is at most three cycles after the corrupted producer issued, because the tag passes through all three tracked stages in that time. A lost empty slot during a stall shows up at once as a repeated stall, or as a select that points at the producer one stage too early. The bench keeps its own tag model built from the requirements and compares all four outputs every cycle. It mixes random register streams over a small register set, to make collisions dense, with directed back-to-back, two-, three- and four-apart cases.

// File: rtl/hz_pkg.sv
package hz_pkg;

  // Downstream stages tracked by the controller, youngest first
  localparam int unsigned HZ_NSTG = 3;
  localparam int unsigned STG_EXA = 0;
  localparam int unsigned STG_EXB = 1;
  localparam int unsigned STG_WB  = 2;

  // Operand source encoding seen by the bypass muxes
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_EXB = 2'b01,
    FWD_WB  = 2'b10
  } fwd_sel_e;

endpackage

// File: rtl/hz_rst_sync.sv
module hz_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/hz_tag_pipe.sv
module hz_tag_pipe
  import hz_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            hold_i,
  input  logic                            issue_vld_i,
  input  logic                            issue_we_i,
  input  logic [ADDR_W-1:0]               issue_rd_i,
  output logic [HZ_NSTG-1:0]              stg_wr_o,
  output logic [HZ_NSTG-1:0][ADDR_W-1:0]  stg_rd_o
);

  logic [HZ_NSTG-1:0]             vld_q, vld_d;
  logic [HZ_NSTG-1:0]             we_q,  we_d;
  logic [HZ_NSTG-1:0][ADDR_W-1:0] rd_q,  rd_d;
  logic                           adv_en;

  // The tag pipe always advances; a stall only swaps the EX-A entry for an empty slot
  assign adv_en = 1'b1;

  // Entry stage: a held decode instruction is replaced by an empty slot
  always_comb begin
    vld_d[STG_EXA] = issue_vld_i & ~hold_i;
    we_d[STG_EXA]  = issue_vld_i & issue_we_i & ~hold_i;
    rd_d[STG_EXA]  = hold_i ? '0 : issue_rd_i;
  end

  // Older stages take their younger neighbour
  for (genvar s = 1; s < HZ_NSTG; s++) begin : g_shift
    always_comb begin
      vld_d[s] = vld_q[s-1];
      we_d[s]  = we_q[s-1];
      rd_d[s]  = rd_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      we_q  <= '0;
      rd_q  <= '0;
    end else if (adv_en) begin
      vld_q <= vld_d;
      we_q  <= we_d;
      rd_q  <= rd_d;
    end
  end

  for (genvar s = 0; s < HZ_NSTG; s++) begin : g_out
    assign stg_wr_o[s] = vld_q[s] & we_q[s] & (rd_q[s] != '0);
    assign stg_rd_o[s] = rd_q[s];
  end

  // R10: a stall cycle leaves an empty, non-writing slot in EX-A
  p_bubble_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> (!vld_q[STG_EXA] && !we_q[STG_EXA]));

  // R10: the producer leaves EX-A even while decode is held
  p_producer_moves_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_i && vld_q[STG_EXA]) |=> vld_q[STG_EXB]);

endmodule

// File: rtl/hz_src_match.sv
module hz_src_match
  import hz_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [ADDR_W-1:0]               rs_i,
  input  logic [HZ_NSTG-1:0]              stg_wr_i,
  input  logic [HZ_NSTG-1:0][ADDR_W-1:0]  stg_rd_i,
  output logic                            hz_o,
  output fwd_sel_e                        sel_o
);

  logic [HZ_NSTG-1:0] hit;

  for (genvar s = 0; s < HZ_NSTG; s++) begin : g_hit
    assign hit[s] = stg_wr_i[s] & (stg_rd_i[s] == rs_i);
  end

  // EX-A holds only a partial result: it can raise a hazard, never a bypass
  always_comb begin
    hz_o = hit[STG_EXA];
    if (hit[STG_EXB])     sel_o = FWD_EXB;
    else if (hit[STG_WB]) sel_o = FWD_WB;
    else                  sel_o = FWD_RF;
  end

  // R8: register 0 is never bypassed
  p_zero_src_rf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_i == '0) |-> (sel_o == FWD_RF && !hz_o));

  // R6: the unused select code never appears
  p_sel_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_o != 2'b11);

  // R5: writeback selected only if EX-B does not also match
  p_wb_not_exb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_o == FWD_WB) |-> !(stg_wr_i[STG_EXB] && stg_rd_i[STG_EXB] == rs_i));

endmodule

// File: rtl/hz_split_alu_ctrl.sv
module hz_split_alu_ctrl
  import hz_pkg::*;
#(
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_valid_i,
  input  logic              id_we_i,
  input  logic [ADDR_W-1:0] id_rd_i,
  input  logic [ADDR_W-1:0] id_rs1_i,
  input  logic [ADDR_W-1:0] id_rs2_i,
  output logic              stall_o,
  output logic              exa_bubble_o,
  output logic [1:0]        fwd_rs1_o,
  output logic [1:0]        fwd_rs2_o
);

  localparam int unsigned NSRC = 2;

  logic                           rst_sync_n;
  logic [HZ_NSTG-1:0]             stg_wr;
  logic [HZ_NSTG-1:0][ADDR_W-1:0] stg_rd;
  logic [NSRC-1:0][ADDR_W-1:0]    src;
  logic [NSRC-1:0]                src_hz;
  fwd_sel_e                       src_sel [NSRC];
  logic                           stall;

  hz_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign src[0] = id_rs1_i;
  assign src[1] = id_rs2_i;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    hz_src_match #(.ADDR_W(ADDR_W)) u_match (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .rs_i     (src[g]),
      .stg_wr_i (stg_wr),
      .stg_rd_i (stg_rd),
      .hz_o     (src_hz[g]),
      .sel_o    (src_sel[g])
    );
  end

  assign stall = id_valid_i & (|src_hz);

  hz_tag_pipe #(.ADDR_W(ADDR_W)) u_tag_pipe (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .hold_i      (stall),
    .issue_vld_i (id_valid_i),
    .issue_we_i  (id_we_i),
    .issue_rd_i  (id_rd_i),
    .stg_wr_o    (stg_wr),
    .stg_rd_o    (stg_rd)
  );

  assign stall_o      = stall;
  assign exa_bubble_o = stall;
  assign fwd_rs1_o    = src_sel[0];
  assign fwd_rs2_o    = src_sel[1];

  // R3: a held consumer never waits a second cycle on the same producer
  p_one_cycle_stall_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stall_o |=> !stall_o);

  // R11: an empty decode slot never stalls
  p_no_stall_invalid_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !id_valid_i |-> !stall_o);

  // R1: nothing is flagged while the synchronised reset is active
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_sync_n |-> (!stall_o && fwd_rs1_o == 2'b00 && fwd_rs2_o == 2'b00));

endmodule

// File: tb/hz_split_alu_ctrl_tb.sv
`timescale 1ns/1ps
module hz_split_alu_ctrl_tb;

  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          id_valid, id_we;
  logic [AW-1:0] id_rd, id_rs1, id_rs2;
  logic          stall, bubble;
  logic [1:0]    f1, f2;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // bench model of the tracked stages: 0 EX-A, 1 EX-B, 2 writeback
  logic          m_vld [3];
  logic          m_we  [3];
  logic [AW-1:0] m_rd  [3];

  always #2.5 clk = ~clk;

  hz_split_alu_ctrl #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .id_valid_i(id_valid), .id_we_i(id_we),
    .id_rd_i(id_rd), .id_rs1_i(id_rs1), .id_rs2_i(id_rs2),
    .stall_o(stall), .exa_bubble_o(bubble), .fwd_rs1_o(f1), .fwd_rs2_o(f2)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic m_writes(int s);
    return m_vld[s] && m_we[s] && (m_rd[s] != '0);
  endfunction

  function automatic logic [1:0] exp_sel(logic [AW-1:0] rs);
    if (m_writes(1) && m_rd[1] == rs) return 2'b01;
    if (m_writes(2) && m_rd[2] == rs) return 2'b10;
    return 2'b00;
  endfunction

  function automatic logic exp_stall(logic v, logic [AW-1:0] a, logic [AW-1:0] b);
    return v && m_writes(0) && (m_rd[0] == a || m_rd[0] == b);
  endfunction

  function automatic string sel_req(logic [1:0] e);
    return (e == 2'b01) ? "R4" : (e == 2'b10) ? "R5" : "R6";
  endfunction

  task automatic model_clear();
    for (int s = 0; s < 3; s++) begin
      m_vld[s] = 1'b0; m_we[s] = 1'b0; m_rd[s] = '0;
    end
  endtask

  // Present one instruction; repeat it while stalled. Returns stall count and final selects.
  task automatic issue(input logic v, input logic we, input logic [AW-1:0] rd,
                       input logic [AW-1:0] rs1, input logic [AW-1:0] rs2,
                       output int nst, output logic [1:0] s1, output logic [1:0] s2);
    logic st;
    nst = 0;
    do begin
      @(negedge clk);
      id_valid = v; id_we = we; id_rd = rd; id_rs1 = rs1; id_rs2 = rs2;
      #1;
      st = exp_stall(v, rs1, rs2);
      chk(v ? "R2" : "R11", {31'd0, stall}, {31'd0, st});
      chk("R2", {31'd0, bubble}, {31'd0, st});
      chk(sel_req(exp_sel(rs1)), {30'd0, f1}, {30'd0, exp_sel(rs1)});
      chk(sel_req(exp_sel(rs2)), {30'd0, f2}, {30'd0, exp_sel(rs2)});
      s1 = f1; s2 = f2;
      if (st) nst++;
      @(posedge clk);
      m_vld[2] = m_vld[1]; m_we[2] = m_we[1]; m_rd[2] = m_rd[1];
      m_vld[1] = m_vld[0]; m_we[1] = m_we[0]; m_rd[1] = m_rd[0];
      m_vld[0] = v && !st; m_we[0] = v && we && !st; m_rd[0] = st ? '0 : rd;
    end while (st && nst < 4);
  endtask

  task automatic flush();
    int n; logic [1:0] a, b;
    for (int i = 0; i < 3; i++) issue(1'b0, 1'b0, '0, '0, '0, n, a, b);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n; logic [1:0] a, b;
    void'($urandom(32'h5EED_0C1A));
    model_clear();
    rst_n = 1'b0; id_valid = 1'b1; id_we = 1'b1; id_rd = 5'd3; id_rs1 = 5'd3; id_rs2 = 5'd3;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", {31'd0, stall}, 32'd0);
    chk("R1", {30'd0, f1}, 32'd0);
    chk("R1", {30'd0, f2}, 32'd0);
    id_valid = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R1", {31'd0, stall}, 32'd0);
    chk("R1", {30'd0, f1 | f2}, 32'd0);

    // R3: back-to-back producer/consumer
    issue(1, 1, 5'd5, 5'd1, 5'd2, n, a, b);
    issue(1, 1, 5'd6, 5'd5, 5'd0, n, a, b);
    chk("R3", n, 1); chk("R3", {30'd0, a}, 32'd1);
    flush();
    // R4: two apart, bypass from EX-B
    issue(1, 1, 5'd6, 5'd0, 5'd0, n, a, b);
    issue(1, 0, 5'd0, 5'd0, 5'd0, n, a, b);
    issue(1, 1, 5'd1, 5'd0, 5'd6, n, a, b);
    chk("R4", n, 0); chk("R4", {30'd0, b}, 32'd1);
    flush();
    // R5: three apart, from writeback
    issue(1, 1, 5'd7, 5'd0, 5'd0, n, a, b);
    issue(1, 0, 5'd0, 5'd0, 5'd0, n, a, b);
    issue(1, 0, 5'd0, 5'd0, 5'd0, n, a, b);
    issue(1, 1, 5'd1, 5'd7, 5'd0, n, a, b);
    chk("R5", n, 0); chk("R5", {30'd0, a}, 32'd2);
    flush();
    // R6: four apart, register file
    issue(1, 1, 5'd8, 5'd0, 5'd0, n, a, b);
    for (int i = 0; i < 3; i++) issue(1, 0, 5'd0, 5'd0, 5'd0, n, a, b);
    issue(1, 1, 5'd1, 5'd8, 5'd0, n, a, b);
    chk("R6", n, 0); chk("R6", {30'd0, a}, 32'd0);
    flush();
    // R7: EX-B beats writeback
    issue(1, 1, 5'd9, 5'd0, 5'd0, n, a, b);
    issue(1, 1, 5'd9, 5'd0, 5'd0, n, a, b);
    issue(1, 0, 5'd0, 5'd0, 5'd0, n, a, b);
    issue(1, 1, 5'd1, 5'd9, 5'd9, n, a, b);
    chk("R7", {30'd0, a}, 32'd1); chk("R7", {30'd0, b}, 32'd1);
    flush();
    // R8: destination 0 and write-disabled producers are ignored
    issue(1, 1, 5'd0, 5'd0, 5'd0, n, a, b);
    issue(1, 1, 5'd1, 5'd0, 5'd0, n, a, b);
    chk("R8", n, 0); chk("R8", {30'd0, a}, 32'd0);
    issue(1, 0, 5'd10, 5'd0, 5'd0, n, a, b);
    issue(1, 1, 5'd1, 5'd10, 5'd10, n, a, b);
    chk("R8", n, 0); chk("R8", {30'd0, a | b}, 32'd0);
    flush();
    // R9: second operand alone stalls; operands pick different sources
    issue(1, 1, 5'd11, 5'd0, 5'd0, n, a, b);
    issue(1, 1, 5'd1, 5'd3, 5'd11, n, a, b);
    chk("R9", n, 1); chk("R9", {30'd0, a}, 32'd0); chk("R9", {30'd0, b}, 32'd1);
    flush();
    issue(1, 1, 5'd12, 5'd0, 5'd0, n, a, b);
    issue(1, 1, 5'd13, 5'd0, 5'd0, n, a, b);
    issue(1, 0, 5'd0, 5'd0, 5'd0, n, a, b);
    issue(1, 1, 5'd1, 5'd12, 5'd13, n, a, b);
    chk("R9", {30'd0, a}, 32'd2); chk("R9", {30'd0, b}, 32'd1);
    flush();
    // R10: held instruction issues once after the empty slot, then feeds its own consumer
    issue(1, 1, 5'd14, 5'd0, 5'd0, n, a, b);
    issue(1, 1, 5'd15, 5'd14, 5'd0, n, a, b);
    chk("R10", n, 1);
    issue(1, 1, 5'd2, 5'd15, 5'd0, n, a, b);
    chk("R10", n, 1); chk("R10", {30'd0, a}, 32'd1);
    flush();
    // R11: invalid decode slot over a would-be hazard
    issue(1, 1, 5'd4, 5'd0, 5'd0, n, a, b);
    issue(0, 1, 5'd4, 5'd4, 5'd4, n, a, b);
    chk("R11", n, 0);
    flush();

    // Random traffic over a small register set
    for (int i = 0; i < 3000; i++) begin
      logic v, we;
      v  = ($urandom % 10) != 0;
      we = ($urandom % 5) != 0;
      issue(v, we, AW'($urandom % 4), AW'($urandom % 4), AW'($urandom % 4), n, a, b);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule